// File: doc/BRIEF.md
# Serial Audio Interrupt Vector Arbiter

This block collects six interrupt requests from a stereo serial audio port and presents one of them at a time to a processor core as a vector address. There are three transmit sources and three receive sources. Each side has a left-channel source, a right-channel source and an exception source. A request pulse is stored in a pending bit. Among the pending sources that are enabled, a fixed priority picks the winner. The winner's vector address is registered and presented with a valid flag until the core acknowledges it.

Each source owns one two-word slot. The transmit slots and the receive slots can each be moved between a low base and a high base, under separate relocation bits. The core writes the relocation bits through a write strobe. A single acknowledge input retires whichever source is currently presented.

Top module: `sai_irq_arbiter`

## Requirements
- R1: A synchronous reset clears all pending bits, clears both relocation bits, and drives valid_o to 0 and vec_o to 0.
- R2: A 1 on req_i[i] at a clock edge sets pending bit i. If en_i[i] is 1, the source can be presented on the outputs after that same edge.
- R3: Source index i has this order: 0 left transmit, 1 right transmit, 2 transmit exception, 3 left receive, 4 right receive, 5 receive exception. When its group's relocation bit is 0, source i presents vector 0x0010 + 2*i.
- R4: When its group's relocation bit is 1, source i presents vector 0x0040 + 2*i.
- R5: The transmit relocation bit moves only sources 0 to 2. The receive relocation bit moves only sources 3 to 5.
- R6: Among the eligible sources, the winner is chosen in this order, highest first: 5, 2, 3, 0, 4, 1.
- R7: A pending source with its enable at 0 is never presented. It keeps its pending bit and competes again once its enable returns to 1.
- R8: valid_o is 1 exactly when at least one enabled source is pending. vec_o reads 0 while valid_o is 0.
- R9: While valid_o is 1, the output stays unchanged as long as ack_i is 0 and the presented source stays enabled. This holds even when a higher-priority request arrives.
- R10: ack_i high while valid_o is 1 clears the pending bit of the presented source only. The next winner is presented after that same edge.
- R11: If req_i of the presented source is 1 in the same cycle as ack_i, the pending bit stays set.
- R12: reloc_we_i loads tx_reloc_i and rx_reloc_i into the relocation bits. The new bits apply to the next selection and do not alter a vector that is being held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 6 | Request pulses, indexed as in R3 |
| en_i | input | 6 | Per-source enables |
| ack_i | input | 1 | Acknowledge of the presented vector |
| reloc_we_i | input | 1 | Write strobe for the relocation bits |
| tx_reloc_i | input | 1 | New transmit relocation bit |
| rx_reloc_i | input | 1 | New receive relocation bit |
| vec_o | output | ADDR_W (16) | Registered vector address |
| valid_o | output | 1 | A vector is being presented |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is an acknowledge and a fresh request of the same source, which tests whether the clear or the set wins. The second pair is a relocation write and a held vector, which tests whether the held address changes. Directed sequences provoke both collisions on purpose. Random stimulus then mixes requests, acknowledges, enable changes and relocation writes in shared cycles. A bench model, built from the requirements alone, predicts the pending set, the hold rule and the address. It judges valid_o and vec_o every cycle.

// File: rtl/sai_irq_pkg.sv
package sai_irq_pkg;

    localparam int NSRC  = 6;
    localparam int SRC_W = 3;

    typedef enum logic [SRC_W-1:0] {
        SRC_TX_L   = 3'd0,
        SRC_TX_R   = 3'd1,
        SRC_TX_EXC = 3'd2,
        SRC_RX_L   = 3'd3,
        SRC_RX_R   = 3'd4,
        SRC_RX_EXC = 3'd5
    } src_e;

    typedef struct packed {
        logic valid;
        src_e src;
    } grant_t;

    typedef struct packed {
        logic tx_hi;
        logic rx_hi;
    } reloc_t;

    // Rank 0 is the strongest claim.
    function automatic src_e src_at_rank(input int r);
        case (r)
            0:       return SRC_RX_EXC;
            1:       return SRC_TX_EXC;
            2:       return SRC_RX_L;
            3:       return SRC_TX_L;
            4:       return SRC_RX_R;
            default: return SRC_TX_R;
        endcase
    endfunction

    function automatic logic is_rx(input src_e s);
        return (s >= SRC_RX_L);
    endfunction

endpackage

// File: rtl/sai_irq_pending.sv
module sai_irq_pending #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o,
    output logic [N-1:0] pend_next_o
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic q;

        // a new request outranks a clear in the same cycle
        assign pend_next_o[g] = set_i[g] | (q & ~clr_i[g]);

        always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= pend_next_o[g];
        end

        assign pend_o[g] = q;

        // R2 R11
        pend_set_chk: assert property (@(posedge clk) disable iff (rst)
            set_i[g] |=> q);

        // R10
        pend_clr_chk: assert property (@(posedge clk) disable iff (rst)
            (clr_i[g] && !set_i[g]) |=> !q);
    end

endmodule

// File: rtl/sai_irq_picker.sv
module sai_irq_picker
    import sai_irq_pkg::*;
(
    input  logic [NSRC-1:0] elig_i,
    output grant_t          grant_o
);

    // walk from weakest to strongest so the strongest claim is written last
    always_comb begin
        grant_o = '0;
        for (int r = NSRC - 1; r >= 0; r--) begin
            if (elig_i[src_at_rank(r)]) begin
                grant_o.valid = 1'b1;
                grant_o.src   = src_at_rank(r);
            end
        end
    end

    // R6
    pick_elig_chk: assert final (!grant_o.valid || elig_i[grant_o.src]);

endmodule

// File: rtl/sai_irq_vecgen.sv
module sai_irq_vecgen
    import sai_irq_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BASE_LO   = 'h10,
    parameter int BASE_HI   = 'h40,
    parameter int SLOT_STEP = 2
) (
    input  src_e              src_i,
    input  reloc_t            reloc_i,
    output logic [ADDR_W-1:0] vec_o
);

    localparam logic [ADDR_W-1:0] LO = ADDR_W'(BASE_LO);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(BASE_HI);

    logic hi_sel;

    always_comb begin
        hi_sel = is_rx(src_i) ? reloc_i.rx_hi : reloc_i.tx_hi;
        vec_o  = (hi_sel ? HI : LO) + ADDR_W'(SLOT_STEP * int'(src_i));
    end

endmodule

// File: rtl/sai_irq_arbiter.sv
module sai_irq_arbiter
    import sai_irq_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BASE_LO   = 'h10,
    parameter int BASE_HI   = 'h40,
    parameter int SLOT_STEP = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   req_i,
    input  logic [NSRC-1:0]   en_i,
    input  logic              ack_i,
    input  logic              reloc_we_i,
    input  logic              tx_reloc_i,
    input  logic              rx_reloc_i,
    output logic [ADDR_W-1:0] vec_o,
    output logic              valid_o
);

    reloc_t            reloc_q, reloc_d;
    grant_t            cur_q, pick;
    logic [NSRC-1:0]   clr, pend_q, pend_d, elig;
    logic [ADDR_W-1:0] vec_q, pick_vec;
    logic              hold;

    always_comb begin
        reloc_d = reloc_q;
        if (reloc_we_i) begin
            reloc_d.tx_hi = tx_reloc_i;
            reloc_d.rx_hi = rx_reloc_i;
        end
    end

    always_comb begin
        clr = '0;
        if (cur_q.valid && ack_i) clr[cur_q.src] = 1'b1;
    end

    sai_irq_pending #(.N(NSRC)) u_pend (
        .clk        (clk),
        .rst        (rst),
        .set_i      (req_i),
        .clr_i      (clr),
        .pend_o     (pend_q),
        .pend_next_o(pend_d)
    );

    // arbitrate on next-state pending so an acknowledged source is not re-presented
    assign elig = pend_d & en_i;

    sai_irq_picker u_pick (
        .elig_i (elig),
        .grant_o(pick)
    );

    sai_irq_vecgen #(
        .ADDR_W   (ADDR_W),
        .BASE_LO  (BASE_LO),
        .BASE_HI  (BASE_HI),
        .SLOT_STEP(SLOT_STEP)
    ) u_vec (
        .src_i  (pick.src),
        .reloc_i(reloc_d),
        .vec_o  (pick_vec)
    );

    assign hold = cur_q.valid && !ack_i && en_i[cur_q.src];

    always_ff @(posedge clk) begin
        if (rst) begin
            reloc_q <= '0;
            cur_q   <= '0;
            vec_q   <= '0;
        end else begin
            reloc_q <= reloc_d;
            if (!hold) begin
                cur_q <= pick;
                vec_q <= pick.valid ? pick_vec : '0;
            end
        end
    end

    assign valid_o = cur_q.valid;
    assign vec_o   = vec_q;

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (!valid_o && vec_o == '0 && reloc_q == '0));

    // R9
    vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !ack_i && en_i[cur_q.src]) |=> (valid_o && $stable(vec_o)));

    // R8
    shown_pending_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> pend_q[cur_q.src]);

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> (vec_o == '0));

endmodule

// File: tb/sai_irq_arbiter_tb_top.sv
module sai_irq_arbiter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N = 6;

    logic        clk = 1'b0;
    logic        rst;
    logic [N-1:0] req, en;
    logic        ack, we, txr, rxr;
    logic [15:0] vec;
    logic        valid;

    int checks = 0;
    int failures = 0;

    // reference state
    logic [N-1:0] m_pend;
    logic         m_tx, m_rx, m_valid;
    int           m_src;
    logic [15:0]  m_vec;

    always #(CLK_PERIOD/2) clk = ~clk;

    sai_irq_arbiter dut_i (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req),
        .en_i      (en),
        .ack_i     (ack),
        .reloc_we_i(we),
        .tx_reloc_i(txr),
        .rx_reloc_i(rxr),
        .vec_o     (vec),
        .valid_o   (valid)
    );

    function automatic logic [15:0] exp_addr(input int s, input logic tx, input logic rx);
        logic hi;
        hi = (s >= 3) ? rx : tx;
        return (hi ? 16'h0040 : 16'h0010) + 16'(2 * s);
    endfunction

    function automatic int best(input logic [N-1:0] elig);
        int order [6] = '{5, 2, 3, 0, 4, 1};
        for (int k = 0; k < 6; k++)
            if (elig[order[k]]) return order[k];
        return -1;
    endfunction

    task automatic chk(input string tag, input string what, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic model_edge();
        logic [N-1:0] pd;
        int p;
        pd = m_pend;
        if (m_valid && ack) pd[m_src] = 1'b0;
        pd = pd | req;
        if (we) begin m_tx = txr; m_rx = rxr; end
        if (!(m_valid && !ack && en[m_src])) begin
            p = best(pd & en);
            if (p < 0) begin m_valid = 1'b0; m_vec = 16'h0; end
            else begin m_valid = 1'b1; m_src = p; m_vec = exp_addr(p, m_tx, m_rx); end
        end
        m_pend = pd;
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag, "valid", {15'b0, valid}, {15'b0, m_valid});
        chk(tag, "vec", vec, m_vec);
        req = '0; ack = 1'b0; we = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; req = '0; en = '1; ack = 0; we = 0; txr = 0; rxr = 0;
        m_pend = '0; m_tx = 0; m_rx = 0; m_valid = 0; m_src = 0; m_vec = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", "valid", {15'b0, valid}, 16'h0);
        chk("R1", "vec", vec, 16'h0);

        // R2 / R3: each source alone, low group right after reset (R1 reloc cleared)
        for (int i = 0; i < N; i++) begin
            req = 6'(1 << i); step("R2");
            chk("R3", "addr", vec, 16'h0010 + 16'(2 * i));
            ack = 1'b1; step("R10");
        end

        // R4 / R5: transmit group high, receive group low
        we = 1; txr = 1; rxr = 0; step("R12");
        req = 6'b000001; step("R4");
        chk("R4", "addr", vec, 16'h0040);
        ack = 1; step("R10");
        req = 6'b001000; step("R5");
        chk("R5", "addr", vec, 16'h0016);
        ack = 1; step("R10");
        we = 1; txr = 0; rxr = 1; step("R12");
        req = 6'b100000; step("R4");
        chk("R4", "addr", vec, 16'h004A);
        ack = 1; step("R10");
        req = 6'b000100; step("R5");
        chk("R5", "addr", vec, 16'h0014);
        ack = 1; step("R10");
        we = 1; txr = 0; rxr = 0; step("R12");

        // R6: all six at once, retire in priority order
        req = 6'h3F; step("R6");
        chk("R6", "first", vec, 16'h001A);
        for (int k = 0; k < 6; k++) begin ack = 1; step("R6"); end
        chk("R6", "drained", {15'b0, valid}, 16'h0);

        // R7: disabled source skipped but retained
        en = 6'b011111; req = 6'b100010; step("R7");
        chk("R7", "addr", vec, 16'h0012);
        ack = 1; step("R7");
        chk("R8", "valid", {15'b0, valid}, 16'h0);
        en = 6'h3F; step("R7");
        chk("R7", "addr", vec, 16'h001A);
        ack = 1; step("R10");

        // R9: higher priority arrival does not disturb presented vector
        req = 6'b000010; step("R9");
        req = 6'b100000; step("R9");
        chk("R9", "addr", vec, 16'h0012);
        ack = 1; step("R9");
        chk("R9", "addr", vec, 16'h001A);
        ack = 1; step("R10");

        // R11: acknowledge and re-request same source together
        req = 6'b000001; step("R11");
        req = 6'b000001; ack = 1; step("R11");
        chk("R11", "valid", {15'b0, valid}, 16'h1);
        chk("R11", "addr", vec, 16'h0010);
        ack = 1; step("R11");
        chk("R11", "valid", {15'b0, valid}, 16'h0);

        // R12: relocation write during a held vector
        req = 6'b000011; step("R12");
        we = 1; txr = 1; rxr = 1; step("R12");
        chk("R12", "held", vec, 16'h0010);
        ack = 1; step("R12");
        chk("R12", "next", vec, 16'h0042);
        ack = 1; step("R12");
        we = 1; txr = 0; rxr = 0; step("R12");

        // random mix, R8 tag covers the overall valid/vector relation
        for (int n = 0; n < 4000; n++) begin
            req = (($urandom % 3) == 0) ? 6'($urandom) : 6'h0;
            en  = (($urandom % 8) == 0) ? 6'($urandom) : 6'h3F;
            ack = 1'($urandom);
            we  = (($urandom % 20) == 0);
            txr = 1'($urandom);
            rxr = 1'($urandom);
            step("R8");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule